// File: doc/BRIEF.md
# Low-Power Mode and Reset Sequencer

This block sits beside a small microcontroller core. It decides when the core's clock runs, when the main oscillator runs, and when the core is held in reset. A decoded instruction stream asks for one of two sleep modes. In the light sleep (HALT) the core clock stops and the oscillator keeps running. In the deep sleep (STOP) both stop. Each sleep mode has its own way out: an enabled interrupt resumes from HALT with no reset, while STOP ends only through a reset, after which the core restarts at its stop-recovery vector.

A single one-shot settle timer runs on an always-on clock and stretches the core reset while the supply and the oscillator settle. It is started by supply recovery, by a watchdog timeout, or by a stop-mode recovery event when the recovery-delay control bit asks for it. A trigger that arrives during a count restarts it. The block also reports which source caused the latest reset, and it keeps the watchdog running when the permanent watchdog option is strapped.

Top module: `lpr_seq_top`

## Requirements
- R1: A rising `pwr_ok_a`, a `wdt_timeout` pulse, or a delayed stop recovery starts the settle timer (SETTLE_CYC cycles). After a single one-cycle `wdt_timeout` pulse, `core_rst_n` is low for exactly SETTLE_CYC+1 cycles. While the synchronized `pwr_ok_a` is low, `core_rst_n` is low.
- R2: A rising `stop_wake_a` while in STOP resets the core. With `smr_dly_en`=0 it does so without the settle delay, and `core_rst_n` is low for exactly 1 cycle. With `smr_dly_en`=1, `core_rst_n` is low for SETTLE_CYC+1 cycles.
- R3: A `wdt_timeout` while in STOP applies the full settle delay (SETTLE_CYC+1 low cycles) even when `smr_dly_en`=0.
- R4: In HALT, `cpu_clk_en`=0 and `osc_en`=1. HALT is left only when some bit of `irq_req & irq_en` is 1. The exit returns to run with `cpu_clk_en`=1 and produces no core reset.
- R5: In STOP, `cpu_clk_en`=0 and `osc_en`=0. Interrupts do not end STOP. Only a reset ends it, and that reset sets `stop_restart`=1, which selects the restart vector 000Ch. A reset taken outside STOP clears `stop_restart` to 0.
- R6: A sleep request is accepted only in run mode, and only when the previous valid opcode was FFh. Then 6Fh enters STOP and 7Fh enters HALT. The same opcode without a preceding FFh is ignored.
- R7: A new trigger during the settle count restarts it. Two `wdt_timeout` pulses 5 cycles apart give SETTLE_CYC+6 low cycles on `core_rst_n`.
- R8: When `wdt_perm`=1 and `wdt_rc_clk`=1, `wdt_run` is 1 in every mode. Otherwise `wdt_run` follows `wdt_sw_en`, except that it is 0 in STOP.
- R9: While the synchronized `ext_rst_na` is low, `core_rst_n` is low. External reset also ends STOP. `core_rst_n` returns high with no settle delay.
- R10: `rst_cause` records the source of the latest reset with the encoding 0 = supply, 1 = watchdog, 2 = stop recovery, 3 = external. Each new reset overwrites it.
- R11: A rising `stop_wake_a` outside STOP has no effect: no core reset occurs.
- R12: During and right after `rst_n`, `core_rst_n`=0, `cpu_clk_en`=1, `osc_en`=1 and `rst_cause`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| pwr_ok_a | input | 1 | Asynchronous supply-good flag |
| ext_rst_na | input | 1 | Asynchronous external reset, active low |
| stop_wake_a | input | 1 | Asynchronous stop-recovery event |
| wdt_timeout | input | 1 | Watchdog timeout pulse, synchronous |
| smr_dly_en | input | 1 | 1 = apply settle delay after stop recovery |
| op_valid | input | 1 | Opcode strobe from the decoder |
| op_byte | input | 8 | Decoded opcode byte |
| irq_req | input | N_IRQ | Pending interrupt requests |
| irq_en | input | N_IRQ | Interrupt enables |
| wdt_sw_en | input | 1 | Software watchdog enable |
| wdt_perm | input | 1 | Permanent watchdog option strap |
| wdt_rc_clk | input | 1 | Watchdog clocked from always-on RC |
| cpu_clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Main oscillator enable |
| core_rst_n | output | 1 | Core reset, active low |
| stop_restart | output | 1 | 1 = restart at stop-recovery vector 000Ch |
| wdt_run | output | 1 | Watchdog run enable |
| rst_cause | output | 2 | Source of the latest reset |

## Verification
The bench measures the width of each `core_rst_n` low pulse. This separates a delayed reset (SETTLE_CYC+1), a bypassed stop recovery (1), and a restarted count (SETTLE_CYC+6). A table of opcode pairs tests the sleep-entry rule. It sends each sleep opcode with a prior FFh, without one, and in reversed order, and reads both enables to tell HALT, STOP and run apart. Directed tests then wake each mode by every allowed and disallowed means: interrupts with and without enable, the stop event with either bypass setting, the watchdog, and the external reset. After each wake the bench compares the reset count, `stop_restart` and `rst_cause`.

// File: rtl/lpr_pkg.sv
// Shared types for the low-power mode and reset sequencer.
// Assumes: opcode bytes arrive already decoded from the instruction stream.
package lpr_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_HALT = 2'd1,
        MODE_STOP = 2'd2
    } lpr_mode_e;

    typedef enum logic [1:0] {
        CAUSE_POR = 2'd0,
        CAUSE_WDT = 2'd1,
        CAUSE_SMR = 2'd2,
        CAUSE_EXT = 2'd3
    } lpr_cause_e;

    localparam logic [7:0] OP_NOP  = 8'hFF;
    localparam logic [7:0] OP_STOP = 8'h6F;
    localparam logic [7:0] OP_HALT = 8'h7F;
endpackage

// File: rtl/lpr_sync.sv
// Two-flop synchronizer bank into the always-on clock domain.
// Assumes: each bit is an independent level; RESET_VAL sets the post-reset level.
module lpr_sync #(
    parameter int WIDTH = 1,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    // Two register stages per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RESET_VAL;
            q    <= RESET_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/lpr_settle_timer.sv
// One-shot settle timer: loads SETTLE_CYC on a trigger and counts down to zero.
// A trigger during a count restarts it. Assumes SETTLE_CYC >= 1.
module lpr_settle_timer #(
    parameter int SETTLE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

    logic [CW-1:0] count;

    // Load on a trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (trig)
            count <= LOAD;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign busy = (count != '0);

    AST_TRIG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (count == LOAD)); // R7
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && count != '0) |=> (count == $past(count) - 1'b1)); // R1
endmodule

// File: rtl/lpr_mode_fsm.sv
// Power-mode state machine: run, HALT and STOP.
// Sleep entry needs a NOP opcode just before the sleep opcode. HALT ends on an
// enabled interrupt; any reset (hold) forces run mode.
// Assumes hold is high for every cycle in which the core is being reset.
module lpr_mode_fsm (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              op_valid,
    input  logic [7:0]        op_byte,
    input  logic              wake,
    output lpr_pkg::lpr_mode_e mode
);
    import lpr_pkg::*;

    logic nop_seen;

    // Mode register and pipeline-flushed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_RUN;
            nop_seen <= 1'b0;
        end else if (hold) begin
            mode     <= MODE_RUN;
            nop_seen <= 1'b0;
        end else begin
            case (mode)
                MODE_RUN: begin
                    if (op_valid) begin
                        nop_seen <= (op_byte == OP_NOP);
                        if (nop_seen && op_byte == OP_STOP)
                            mode <= MODE_STOP;
                        else if (nop_seen && op_byte == OP_HALT)
                            mode <= MODE_HALT;
                    end
                end
                MODE_HALT: begin
                    if (wake)
                        mode <= MODE_RUN;
                end
                MODE_STOP: mode <= MODE_STOP;
                default:   mode <= MODE_RUN;
            endcase
        end
    end

    AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALT && !wake && !hold) |=> (mode == MODE_HALT)); // R4
    AST_STOP_NEEDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STOP && !hold) |=> (mode == MODE_STOP)); // R5
    AST_ENTRY_AFTER_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && !nop_seen) |=> (mode == MODE_RUN)); // R6
endmodule

// File: rtl/lpr_seq_top.sv
// Low-power mode and reset sequencer top.
// Synchronizes the asynchronous supply, external-reset and wake inputs, starts
// the settle timer, drives the clock, oscillator and core-reset outputs, and logs
// the reset cause.
// Assumes clk is always on and wdt_timeout/op_*/irq_* are synchronous to clk.
module lpr_seq_top #(
    parameter int SETTLE_CYC = 64,
    parameter int N_IRQ      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_ok_a,
    input  logic             ext_rst_na,
    input  logic             stop_wake_a,
    input  logic             wdt_timeout,
    input  logic             smr_dly_en,
    input  logic             op_valid,
    input  logic [7:0]       op_byte,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_sw_en,
    input  logic             wdt_perm,
    input  logic             wdt_rc_clk,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             core_rst_n,
    output logic             stop_restart,
    output logic             wdt_run,
    output logic [1:0]       rst_cause
);
    import lpr_pkg::*;

    logic [2:0] async_s;
    logic       pwr_s, ext_s, wake_s;
    logic       pwr_prev, ext_prev, wake_prev;
    logic       por_trig, wdt_trig, smr_evt, ext_fall;
    logic       tmr_trig, settle_busy, hold, rst_evt, wake_irq;
    lpr_mode_e  mode;
    lpr_cause_e cause_q;

    lpr_sync #(.WIDTH(3), .RESET_VAL(3'b000)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({stop_wake_a, ext_rst_na, pwr_ok_a}),
        .q     (async_s)
    );
    assign pwr_s  = async_s[0];
    assign ext_s  = async_s[1];
    assign wake_s = async_s[2];

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_prev  <= 1'b0;
            ext_prev  <= 1'b0;
            wake_prev <= 1'b0;
        end else begin
            pwr_prev  <= pwr_s;
            ext_prev  <= ext_s;
            wake_prev <= wake_s;
        end
    end

    // Reset events and the settle-timer trigger.
    always_comb begin
        por_trig = pwr_s && !pwr_prev;
        wdt_trig = wdt_timeout;
        smr_evt  = wake_s && !wake_prev && (mode == MODE_STOP);
        ext_fall = ext_prev && !ext_s;
        tmr_trig = por_trig || wdt_trig || (smr_evt && smr_dly_en);
        rst_evt  = por_trig || wdt_trig || smr_evt || ext_fall;
        hold     = !pwr_s || !ext_s || settle_busy || rst_evt;
        wake_irq = |(irq_req & irq_en);
    end

    lpr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (tmr_trig),
        .busy  (settle_busy)
    );

    lpr_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .op_valid (op_valid),
        .op_byte  (op_byte),
        .wake     (wake_irq),
        .mode     (mode)
    );

    // Registered core reset output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            core_rst_n <= 1'b0;
        else
            core_rst_n <= !hold;
    end

    // Reset cause log and restart-vector select, updated on each reset event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q      <= CAUSE_POR;
            stop_restart <= 1'b0;
        end else if (rst_evt) begin
            stop_restart <= (mode == MODE_STOP);
            if (por_trig)      cause_q <= CAUSE_POR;
            else if (wdt_trig) cause_q <= CAUSE_WDT;
            else if (ext_fall) cause_q <= CAUSE_EXT;
            else               cause_q <= CAUSE_SMR;
        end
    end

    // Clock, oscillator and watchdog enables from the mode.
    always_comb begin
        cpu_clk_en = (mode == MODE_RUN);
        osc_en     = (mode != MODE_STOP);
        wdt_run    = (wdt_perm && wdt_rc_clk) || (wdt_sw_en && mode != MODE_STOP);
        rst_cause  = cause_q;
    end

    AST_BUSY_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        settle_busy |=> !core_rst_n); // R1
    AST_BYPASS_SKIPS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (smr_evt && !smr_dly_en && !por_trig && !wdt_trig && !settle_busy) |=> !settle_busy); // R2
    AST_WDT_STOP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_trig && mode == MODE_STOP) |=> settle_busy); // R3
    AST_EXT_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_s |=> !core_rst_n); // R9
endmodule

// File: tb/lpr_seq_top_tb.sv
module lpr_seq_top_tb;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok_a = 1'b1, ext_rst_na = 1'b1, stop_wake_a = 1'b0;
    logic wdt_timeout = 1'b0, smr_dly_en = 1'b0, op_valid = 1'b0;
    logic [7:0] op_byte = 8'h00;
    logic [3:0] irq_req = 4'h0, irq_en = 4'h0;
    logic wdt_sw_en = 1'b0, wdt_perm = 1'b0, wdt_rc_clk = 1'b0;
    logic cpu_clk_en, osc_en, core_rst_n, stop_restart, wdt_run;
    logic [1:0] rst_cause;

    int total = 0, bad = 0, cyc = 0, fall_cyc = 0, low_len = 0, fall_cnt = 0;
    logic prev_rst = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    lpr_seq_top #(.SETTLE_CYC(N), .N_IRQ(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok_a(pwr_ok_a), .ext_rst_na(ext_rst_na),
        .stop_wake_a(stop_wake_a), .wdt_timeout(wdt_timeout), .smr_dly_en(smr_dly_en),
        .op_valid(op_valid), .op_byte(op_byte), .irq_req(irq_req), .irq_en(irq_en),
        .wdt_sw_en(wdt_sw_en), .wdt_perm(wdt_perm), .wdt_rc_clk(wdt_rc_clk),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .core_rst_n(core_rst_n),
        .stop_restart(stop_restart), .wdt_run(wdt_run), .rst_cause(rst_cause)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Measures the width of each core reset pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_rst && !core_rst_n) begin
                fall_cyc = cyc;
                fall_cnt = fall_cnt + 1;
            end
            if (!prev_rst && core_rst_n) low_len = cyc - fall_cyc;
        end
        prev_rst = core_rst_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_op(input logic [7:0] b);
        @(negedge clk); op_valid = 1'b1; op_byte = b;
        @(negedge clk); op_valid = 1'b0; op_byte = 8'h00;
    endtask

    task automatic pulse_wdt();
        @(negedge clk); wdt_timeout = 1'b1;
        @(negedge clk); wdt_timeout = 1'b0;
    endtask

    task automatic recover();
        pulse_wdt();
        wait_cyc(N + 8);
    endtask

    // {op1, op2, expected cpu_clk_en, expected osc_en}
    localparam logic [17:0] VEC [6] = '{
        {8'hFF, 8'h7F, 1'b0, 1'b1},
        {8'hFF, 8'h6F, 1'b0, 1'b0},
        {8'h00, 8'h7F, 1'b1, 1'b1},
        {8'h00, 8'h6F, 1'b1, 1'b1},
        {8'h7F, 8'hFF, 1'b1, 1'b1},
        {8'h6F, 8'h6F, 1'b1, 1'b1}
    };

    initial begin
        int fc;
        wait_cyc(4);
        chk(core_rst_n == 0 && cpu_clk_en == 1 && osc_en == 1, "R12 reset outputs",
            {core_rst_n, cpu_clk_en, osc_en}, 3'b011);
        rst_n = 1'b1;
        @(negedge clk);
        chk(core_rst_n == 0 && rst_cause == 0, "R12 after release", {core_rst_n, rst_cause}, 0);
        wait_cyc(N + 10);
        chk(core_rst_n == 1, "R1 supply-up delay ends", core_rst_n, 1);
        chk(rst_cause == 0, "R10 cause supply", rst_cause, 0);

        pulse_wdt(); wait_cyc(N + 8);
        chk(low_len == N + 1, "R1 wdt pulse width", low_len, N + 1);
        chk(rst_cause == 1, "R10 cause watchdog", rst_cause, 1);

        pulse_wdt(); wait_cyc(3); pulse_wdt(); wait_cyc(N + 10);
        chk(low_len == N + 6, "R7 retrigger width", low_len, N + 6);

        for (int k = 0; k < 6; k++) begin
            send_op(VEC[k][17:10]);
            send_op(VEC[k][9:2]);
            chk(cpu_clk_en == VEC[k][1] && osc_en == VEC[k][0], "R6 entry vector",
                {cpu_clk_en, osc_en}, VEC[k][1:0]);
            recover();
        end

        recover();
        chk(stop_restart == 0, "R5 run reset clears vector select", stop_restart, 0);
        fc = fall_cnt;
        send_op(8'hFF); send_op(8'h7F);
        irq_req = 4'b0100; wait_cyc(6);
        chk(cpu_clk_en == 0 && osc_en == 1, "R4 halt on unenabled irq", {cpu_clk_en, osc_en}, 2'b01);
        irq_en = 4'b0100; wait_cyc(2);
        chk(cpu_clk_en == 1, "R4 enabled irq wakes", cpu_clk_en, 1);
        chk(fall_cnt == fc && core_rst_n == 1, "R4 halt exit without reset", fall_cnt - fc, 0);
        irq_req = 4'h0; irq_en = 4'h0;

        smr_dly_en = 1'b0;
        send_op(8'hFF); send_op(8'h6F);
        irq_req = 4'hF; irq_en = 4'hF; wait_cyc(20);
        chk(cpu_clk_en == 0 && osc_en == 0, "R5 stop ignores irq", {cpu_clk_en, osc_en}, 0);
        irq_req = 4'h0; irq_en = 4'h0;
        stop_wake_a = 1'b1; wait_cyc(10);
        chk(low_len == 1, "R2 bypass width", low_len, 1);
        chk(stop_restart == 1 && cpu_clk_en == 1, "R5 stop restart vector", stop_restart, 1);
        chk(rst_cause == 2, "R10 cause stop recovery", rst_cause, 2);
        stop_wake_a = 1'b0; wait_cyc(4);

        smr_dly_en = 1'b1;
        send_op(8'hFF); send_op(8'h6F);
        stop_wake_a = 1'b1; wait_cyc(N + 10);
        chk(low_len == N + 1, "R2 delayed stop recovery width", low_len, N + 1);
        stop_wake_a = 1'b0; wait_cyc(4);

        smr_dly_en = 1'b0;
        send_op(8'hFF); send_op(8'h6F);
        pulse_wdt(); wait_cyc(N + 8);
        chk(low_len == N + 1, "R3 wdt in stop forces delay", low_len, N + 1);
        chk(stop_restart == 1, "R3 stop restart", stop_restart, 1);

        fc = fall_cnt;
        stop_wake_a = 1'b1; wait_cyc(6); stop_wake_a = 1'b0; wait_cyc(6);
        chk(fall_cnt == fc && core_rst_n == 1, "R11 wake outside stop", fall_cnt - fc, 0);

        send_op(8'hFF); send_op(8'h6F);
        ext_rst_na = 1'b0; wait_cyc(5);
        chk(core_rst_n == 0, "R9 ext holds reset", core_rst_n, 0);
        chk(rst_cause == 3, "R10 cause external", rst_cause, 3);
        ext_rst_na = 1'b1; wait_cyc(5);
        chk(core_rst_n == 1 && cpu_clk_en == 1, "R9 ext release no delay", core_rst_n, 1);
        chk(stop_restart == 1, "R9 ext ends stop", stop_restart, 1);

        wdt_perm = 1'b1; wdt_rc_clk = 1'b1; wdt_sw_en = 1'b0;
        send_op(8'hFF); send_op(8'h6F);
        chk(wdt_run == 1, "R8 permanent wdt in stop", wdt_run, 1);
        recover();
        wdt_perm = 1'b0; wdt_sw_en = 1'b1;
        chk(wdt_run == 1, "R8 sw wdt in run", wdt_run, 1);
        send_op(8'hFF); send_op(8'h6F);
        chk(wdt_run == 0, "R8 sw wdt off in stop", wdt_run, 0);
        recover();

        pwr_ok_a = 1'b0; wait_cyc(5);
        chk(core_rst_n == 0, "R1 supply fail holds reset", core_rst_n, 0);
        pwr_ok_a = 1'b1; wait_cyc(N + 10);
        chk(core_rst_n == 1 && rst_cause == 0, "R1 supply recovery", rst_cause, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule